// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line Status

This block recovers characters from an asynchronous serial line. An external enable pulses at sixteen times the bit rate; the receiver counts those pulses to find the middle of each bit, starting from the falling edge that opens a start bit. Word length (5 to 8 bits), an optional parity bit (even or odd) and one or two stop bits are chosen by plain control inputs. Each finished character lands in a single holding register together with its error flags.

The holding register is presented as a valid/ready stream. `rx_valid` rises when a character is transferred and stays high, with data and flags frozen, until the consumer asserts `rx_ready` in a cycle where `rx_valid` is high. That handshake is the read. The serial line cannot be stalled. A character that completes while the register is still full is dropped, and the overrun flag records the loss. A line held low for an entire frame is reported as a break, not as a framing error.

Top module: `uart_rx_line`

## Requirements
- R1: A falling edge on the synchronised line starts a candidate start bit. It is accepted only if the line is still low at the 8th tick after the edge; otherwise the receiver returns to idle and produces no character.
- R2: Every later bit is sampled 16 ticks after the previous sample. Data bits are assembled least significant bit first.
- R3: `cfg_wlen` selects the word length as 5 + `cfg_wlen` bits (0 = 5 bits, 3 = 8 bits). Unused upper bits of `rx_data` read as 0.
- R4: When `cfg_par_en` is 1, a parity bit follows the data. `cfg_par_even` = 1 expects an even count of ones over data plus parity, and 0 expects an odd count. A mismatch sets `line_status[2]`.
- R5: `cfg_two_stop` = 1 samples two stop bits, and 0 samples one. If any sampled stop bit is 0, `line_status[3]` (framing error) is set.
- R6: If every sampled bit of a frame is 0, `line_status[4]` (break) is set, `rx_data` reads 0, and neither the parity error nor the framing error is reported.
- R7: `rx_valid` (also `line_status[0]`) rises when a character is transferred. It stays high, with `rx_data` and flags unchanged, until a cycle with `rx_valid` and `rx_ready` both high.
- R8: If a character completes while `rx_valid` is high and no read happens in that cycle, the character is discarded and `line_status[1]` (overrun) is set. The held character is kept.
- R9: The read handshake clears `rx_valid` and all four error flags. Each error flag describes the character it is presented with.
- R10: After reset `rx_valid` is 0 and all of `line_status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial input, idle high |
| tick | input | 1 | One-cycle enable at 16x bit rate |
| cfg_wlen | input | 2 | Word length code, bits = 5 + code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| rx_ready | input | 1 | Consumer accepts the held character |
| rx_valid | output | 1 | Character held |
| rx_data | output | 8 | Held character, zero-padded |
| line_status | output | 5 | {break, framing, parity, overrun, ready} |

## Verification
Most internal faults show up at the ports within one frame. A wrong tick count moves the sampling point, so bits shift and data, parity or stop results come out wrong on the next character. A bad bit index or word-length decode shows as wrong or non-zero upper bits. Faults in the holding logic show up on the next handshake: flags that stay set after a read, a lost or replaced character during overrun, or `rx_valid` dropping without a read. The bench catches these by holding the register full across two frames and by comparing every flag field against the frame it sent.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DW      = 8;
  localparam int MIN_LEN = 5;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2
  } rx_state_t;

  typedef struct packed {
    logic [DW-1:0] data;
    logic          perr;
    logic          ferr;
    logic          brk;
  } rx_char_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe <= '1;
        else        pipe <= din;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], din};
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd_s,
  input  logic [1:0] wlen,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       two_stop,
  output logic       done,
  output rx_char_t   chr
);
  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;
  localparam int IW   = $clog2(DW);

  rx_state_t      state;
  logic [CW-1:0]  cnt;
  logic [IW-1:0]  idx;
  logic [DW-1:0]  shreg;
  logic           par_acc;
  logic           all_low;
  logic           stop_bad;
  logic           prev;

  logic [IW-1:0]  last_idx;
  logic           at_mid;
  logic           at_start_chk;
  logic           fin_low;
  logic           fin_ferr;

  assign last_idx     = IW'(MIN_LEN - 1) + IW'(wlen);
  assign at_mid       = tick && (cnt == CW'(OVS - 1));
  assign at_start_chk = tick && (cnt == CW'(HALF - 1));
  assign fin_low      = all_low & ~rxd_s;
  assign fin_ferr     = stop_bad | ~rxd_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      idx      <= '0;
      shreg    <= '0;
      par_acc  <= 1'b0;
      all_low  <= 1'b0;
      stop_bad <= 1'b0;
      prev     <= 1'b1;
      done     <= 1'b0;
      chr      <= '0;
    end else begin
      done <= 1'b0;
      prev <= rxd_s;
      case (state)
        S_IDLE: begin
          if (prev && !rxd_s) begin
            state <= S_START;
            cnt   <= '0;
          end
        end
        S_START: begin
          if (at_start_chk) begin
            cnt <= '0;
            if (!rxd_s) begin
              state    <= S_DATA;
              idx      <= '0;
              shreg    <= '0;
              par_acc  <= 1'b0;
              all_low  <= 1'b1;
              stop_bad <= 1'b0;
            end else begin
              state <= S_IDLE;
            end
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DATA: begin
          if (at_mid) begin
            cnt        <= '0;
            shreg[idx] <= rxd_s;
            par_acc    <= par_acc ^ rxd_s;
            all_low    <= all_low & ~rxd_s;
            if (idx == last_idx) state <= par_en ? S_PAR : S_STOP1;
            else                 idx   <= idx + 1'b1;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PAR: begin
          if (at_mid) begin
            cnt     <= '0;
            par_acc <= par_acc ^ rxd_s;
            all_low <= all_low & ~rxd_s;
            state   <= S_STOP1;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STOP1, S_STOP2: begin
          if (at_mid) begin
            cnt <= '0;
            if (state == S_STOP1 && two_stop) begin
              stop_bad <= ~rxd_s;
              all_low  <= fin_low;
              state    <= S_STOP2;
            end else begin
              state     <= S_IDLE;
              done      <= 1'b1;
              chr.brk   <= fin_low;
              chr.ferr  <= fin_ferr & ~fin_low;
              chr.perr  <= par_en & (par_acc ^ ~par_even) & ~fin_low;
              chr.data  <= fin_low ? '0 : shreg;
            end
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1: a start candidate that is high at the check point is abandoned
  a_r1_false_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_START && at_start_chk && rxd_s) |=> (state == S_IDLE && !done));

  // R3: five-bit words never carry upper bits
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wlen == 2'd0) |-> (chr.data[DW-1:MIN_LEN] == '0));

  // R6: a break never reports parity or framing error
  a_r6_break_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (done && chr.brk) |-> (!chr.ferr && !chr.perr && chr.data == '0));

  // R2: a character completes only from a stop state
  a_r2_done_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(state) == S_STOP1 || $past(state) == S_STOP2));
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
  import uart_rx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  rx_char_t      chr,
  input  logic          rd_ready,
  output logic          valid,
  output logic [DW-1:0] data,
  output logic          perr,
  output logic          ferr,
  output logic          brk,
  output logic          ovr
);
  logic take;
  assign take = valid && rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      perr  <= 1'b0;
      ferr  <= 1'b0;
      brk   <= 1'b0;
      ovr   <= 1'b0;
    end else begin
      if (take) begin
        valid <= 1'b0;
        perr  <= 1'b0;
        ferr  <= 1'b0;
        brk   <= 1'b0;
        ovr   <= 1'b0;
      end
      if (done) begin
        if (valid && !take) begin
          ovr <= 1'b1;
        end else begin
          valid <= 1'b1;
          data  <= chr.data;
          perr  <= chr.perr;
          ferr  <= chr.ferr;
          brk   <= chr.brk;
        end
      end
    end
  end

  // R7: held character persists until read
  a_r7_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !rd_ready) |=> valid);
  a_r7_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !rd_ready) |=> $stable(data));
  // R9: a read leaves no overrun behind
  a_r9_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !ovr);
  // R8: overrun arises only while a character is held
  a_r8_ovr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(valid));
endmodule

// File: rtl/uart_rx_line.sv
module uart_rx_line
  import uart_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rxd,
  input  logic          tick,
  input  logic [1:0]    cfg_wlen,
  input  logic          cfg_par_en,
  input  logic          cfg_par_even,
  input  logic          cfg_two_stop,
  input  logic          rx_ready,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  output logic [4:0]    line_status
);
  logic     rxd_s;
  logic     done;
  rx_char_t chr;
  logic     perr, ferr, brk, ovr;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxd_s)
  );

  uart_rx_frame #(.OVS(OVS)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd_s(rxd_s),
    .wlen(cfg_wlen), .par_en(cfg_par_en), .par_even(cfg_par_even),
    .two_stop(cfg_two_stop), .done(done), .chr(chr)
  );

  uart_rx_hold u_hold (
    .clk(clk), .rst_n(rst_n), .done(done), .chr(chr), .rd_ready(rx_ready),
    .valid(rx_valid), .data(rx_data), .perr(perr), .ferr(ferr),
    .brk(brk), .ovr(ovr)
  );

  assign line_status = {brk, ferr, perr, ovr, rx_valid};

  // R10: nothing is reported straight out of reset
  a_r10_reset_quiet: assert property (@(posedge clk)
    $rose(rst_n) |-> (line_status == '0));
endmodule

// File: tb/uart_rx_line_test.sv
module uart_rx_line_test;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 4;
  localparam int BITCLK     = 16 * TDIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       tick = 1'b0;
  logic [1:0] cfg_wlen = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic       rx_ready = 1'b0;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic [4:0] line_status;

  int errors = 0;
  int checks = 0;
  logic auto_rd = 1'b1;
  logic finished = 1'b0;
  logic [11:0] expq[$];
  string       tagq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  int tcnt = 0;
  always @(posedge clk) begin
    tcnt <= (tcnt == TDIV-1) ? 0 : tcnt + 1;
    tick <= (tcnt == TDIV-1);
  end

  uart_rx_line uut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick(tick),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_two_stop(cfg_two_stop), .rx_ready(rx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .line_status(line_status)
  );

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected item layout: {data[7:0], brk, ferr, perr, ovr}
  task automatic expect_char(input string tag, input logic [7:0] d,
                             input logic b, input logic f, input logic p, input logic o);
    expq.push_back({d, b, f, p, o});
    tagq.push_back(tag);
  endtask

  task automatic hold_bits(input int n);
    repeat (n * BITCLK) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nb, input logic pen,
                            input logic peven, input logic pbad,
                            input logic s1, input logic s2, input logic two);
    logic p;
    cfg_wlen = 2'(nb - 5);
    cfg_par_en = pen;
    cfg_par_even = peven;
    cfg_two_stop = two;
    p = 1'b0;
    rxd = 1'b0; hold_bits(1);
    for (int i = 0; i < nb; i++) begin
      rxd = d[i]; p ^= d[i]; hold_bits(1);
    end
    if (pen) begin
      rxd = (peven ? p : ~p) ^ pbad; hold_bits(1);
    end
    rxd = s1; hold_bits(1);
    if (two) begin rxd = s2; hold_bits(1); end
    rxd = 1'b1; hold_bits(2);
  endtask

  // monitor: pops expected items as characters appear
  always @(negedge clk) begin
    if (rx_ready) rx_ready <= 1'b0;
    else if (auto_rd && rx_valid && rst_n) begin
      if (expq.size() == 0) begin
        check("R7 unexpected character", {rx_data, line_status[4:1]}, 12'h000);
        checks--; errors += 0;
      end else begin
        check(tagq.pop_front(), {rx_data, line_status[4:1]}, expq.pop_front());
      end
      rx_ready <= 1'b1;
    end
  end

  initial begin
    repeat (BITCLK * 3000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R10 reset status", {7'd0, rx_valid, line_status}, 12'h000);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R10 status after release", {7'd0, rx_valid, line_status}, 12'h000);

    expect_char("R2 8N1 A5", 8'hA5, 0, 0, 0, 0);
    send_frame(8'hA5, 8, 0, 0, 0, 1, 1, 0);
    expect_char("R2 8N1 3C", 8'h3C, 0, 0, 0, 0);
    send_frame(8'h3C, 8, 0, 0, 0, 1, 1, 0);
    expect_char("R4 7E1 good", 8'h55, 0, 0, 0, 0);
    send_frame(8'hD5, 7, 1, 1, 0, 1, 1, 0);
    expect_char("R4 7O1 bad parity", 8'h33, 0, 0, 1, 0);
    send_frame(8'h33, 7, 1, 0, 1, 1, 1, 0);
    expect_char("R3 5-bit zero pad", 8'h1F, 0, 0, 0, 0);
    send_frame(8'hFF, 5, 0, 0, 0, 1, 1, 0);
    expect_char("R4 8E1 FF good", 8'hFF, 0, 0, 0, 0);
    send_frame(8'hFF, 8, 1, 1, 0, 1, 1, 0);
    expect_char("R5 6N2 second stop low", 8'h2A, 0, 1, 0, 0);
    send_frame(8'h2A, 6, 0, 0, 0, 1, 0, 1);
    expect_char("R5 6N2 good", 8'h15, 0, 0, 0, 0);
    send_frame(8'h15, 6, 0, 0, 0, 1, 1, 1);
    expect_char("R5 8N1 stop low", 8'h81, 0, 1, 0, 0);
    send_frame(8'h81, 8, 0, 0, 0, 0, 1, 0);

    // R6: whole frame low (start + 8 data + stop), then release
    expect_char("R6 break", 8'h00, 1, 0, 0, 0);
    cfg_wlen = 2'd3; cfg_par_en = 1'b0; cfg_two_stop = 1'b0;
    rxd = 1'b0; hold_bits(12);
    rxd = 1'b1; hold_bits(3);

    // R1: short glitch below the start check point
    rxd = 1'b0; repeat (3 * TDIV) @(negedge clk);
    rxd = 1'b1; hold_bits(12);
    check("R1 glitch ignored", {7'd0, rx_valid, line_status}, 12'h000);

    // R8 / R7: register full across two frames
    auto_rd = 1'b0;
    send_frame(8'h11, 8, 0, 0, 0, 1, 1, 0);
    send_frame(8'h22, 8, 0, 0, 0, 1, 1, 0);
    hold_bits(4);
    check("R7 ready held without read", {11'd0, rx_valid}, 12'h001);
    expect_char("R8 overrun keeps first", 8'h11, 0, 0, 0, 1);
    auto_rd = 1'b1;
    hold_bits(1);
    check("R9 cleared after read", {7'd0, rx_valid, line_status}, 12'h000);

    expect_char("R9 clean after overrun", 8'h99, 0, 0, 0, 0);
    send_frame(8'h99, 8, 0, 0, 0, 1, 1, 0);
    hold_bits(2);
    check("R9 queue drained", 12'(expq.size()), 12'h000);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule